// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a byte-wide SPI master that sits behind a small processor-facing register port. The processor writes a byte to the data register to start a transfer. The byte first lands in a one-deep transmit buffer. It moves into the shift register as soon as the shifter is idle. The shifter then clocks eight bits out on MOSI while it collects eight bits from MISO. When the eighth bit completes, the collected byte is latched into a receive holding register and the receiver-full flag goes up.

The status/control register reports two level flags: buffer empty and receive data waiting. It also holds a two-bit serial-clock rate field and a DMA-style clear mode. In the default mode, receiver-full is cleared by a two-step handshake: a status read that sees the flag set, then a data read. In DMA-style mode, a data read by itself clears the flag. A byte written while a transfer is in flight waits in the buffer and is sent back to back.

Top module: `spi_master_buf`

## Requirements
- R1: After reset, a status read returns 0x40: bit 6 (transmit buffer empty) is 1, bit 7 (receiver full) is 0, bit 2 (DMA-style clear) is 0 and bits 1:0 (rate) are 00. SCLK is low and both flag outputs agree with the status bits.
- R2: A write to the data register (cpu_sel=1) drops tx_empty after that clock edge. If the shifter is idle, the byte enters the shifter on the next edge and tx_empty returns to 1.
- R3: The rate field (control write, cpu_sel=0, wdata bits 1:0) sets the SCLK period. The values 00, 01, 10 and 11 give 2, 8, 32 and 128 bus clocks.
- R4: SCLK idles low. MOSI changes only on the falling SCLK edge. Data leaves most significant bit first, so a slave sampling on the rising edge receives the written byte.
- R5: MISO is sampled on each rising SCLK edge, most significant bit first. A data register read returns the byte received in the last completed transfer.
- R6: receiver-full and the receive register are updated on the same edge. That edge comes 1 + 8·D bus clocks after the write edge, where D is the SCLK divider.
- R7: With bit 2 clear, a status read that returns bit 7 set, followed by a data read, clears receiver-full.
- R8: With bit 2 clear, a data read that has no qualifying status read before it leaves receiver-full set. A status read taken while the flag was clear does not qualify.
- R9: With bit 2 set, a data read alone clears receiver-full.
- R10: A byte written during a transfer holds tx_empty low until the current byte ends. It then enters the shifter on the following edge, so the next receiver-full comes 1 + 8·D clocks after the previous one.
- R11: SCLK is low whenever no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register select: 0 status/control, 1 data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| tx_empty | output | 1 | Transmit buffer empty level |
| rx_full | output | 1 | Received byte waiting level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A corrupted bit counter or divider shows up on the ports. Receiver-full rises at the wrong clock, or the measured SCLK period differs from twice the half period, within one byte time. A broken clear handshake leaves rx_full stuck, or drops it after a bare data read, on the cycle right after the read. A buffer that fails to hand off keeps tx_empty low one cycle longer than expected, or stretches the gap between back-to-back completions past 1 + 8·D clocks.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // Status/control register bit positions
  localparam int ST_RXF = 7;
  localparam int ST_TXE = 6;
  localparam int ST_DMA = 2;

  typedef enum logic { REG_STAT = 1'b0, REG_DATA = 1'b1 } reg_sel_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_W = 2,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  // half period is 4**rate bus clocks
  always_comb begin
    limit = (CNT_W'(1) << {rate, 1'b0}) - CNT_W'(1);
    tick  = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              last_edge;

  always_comb begin
    last_edge = (edge_q == EW'(EDGES - 1));
    done      = busy_q && tick && sclk_q && last_edge;
    busy_d    = busy_q;
    sclk_d    = sclk_q;
    edge_d    = edge_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    if (load) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      edge_d = '0;
      tx_d   = load_byte;
    end else if (busy_q && tick) begin
      edge_d = edge_q + EW'(1);
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[DATA_W-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (last_edge) busy_d = 1'b0;
        else           tx_d   = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[DATA_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              rd_data,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dma_mode,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              tx_empty,
  output logic              rx_full,
  output logic [DATA_W-1:0] rx_hold
);
  logic              buf_full_q, buf_full_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              rxf_q, rxf_d;
  logic              armed_q, armed_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              consume;

  always_comb begin
    load    = buf_full_q && !busy;
    consume = rd_data && (dma_mode || armed_q);

    buf_d      = wr_data ? wdata : buf_q;
    buf_full_d = buf_full_q;
    if (wr_data)   buf_full_d = 1'b1;
    else if (load) buf_full_d = 1'b0;

    armed_d = armed_q;
    if (rd_stat && rxf_q) armed_d = 1'b1;
    if (consume)          armed_d = 1'b0;

    rxf_d  = rxf_q;
    hold_d = hold_q;
    if (done) begin
      rxf_d  = 1'b1;
      hold_d = rx_byte;
    end else if (consume) begin
      rxf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
      rxf_q      <= 1'b0;
      armed_q    <= 1'b0;
      hold_q     <= '0;
    end else begin
      buf_full_q <= buf_full_d;
      buf_q      <= buf_d;
      rxf_q      <= rxf_d;
      armed_q    <= armed_d;
      hold_q     <= hold_d;
    end
  end

  assign load_byte = buf_q;
  assign tx_empty  = !buf_full_q;
  assign rx_full   = rxf_q;
  assign rx_hold   = hold_q;
endmodule

// File: rtl/spi_master_buf.sv
module spi_master_buf #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  import spi_pkg::*;

  localparam int CNT_W = 2 * ((1 << RATE_W) - 1) + 1;

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              dma_q, dma_d;
  logic              wr_ctrl, wr_data, rd_stat, rd_data;
  logic              tick, busy, done, load;
  logic [DATA_W-1:0] load_byte, rx_byte, rx_hold;
  logic              unused_wbits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  always_comb begin
    wr_ctrl = cpu_wr && (cpu_sel == REG_STAT);
    wr_data = cpu_wr && (cpu_sel == REG_DATA);
    rd_stat = cpu_rd && (cpu_sel == REG_STAT);
    rd_data = cpu_rd && (cpu_sel == REG_DATA);
    rate_d  = wr_ctrl ? cpu_wdata[RATE_W-1:0] : rate_q;
    dma_d   = wr_ctrl ? cpu_wdata[ST_DMA]     : dma_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rate_q <= '0;
      dma_q  <= 1'b0;
    end else begin
      rate_q <= rate_d;
      dma_q  <= dma_d;
    end
  end

  assign unused_wbits = ^cpu_wdata;

  spi_rate_gen #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_q), .run(busy), .rate(rate_q), .tick(tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .load(load), .load_byte(load_byte),
    .tick(tick), .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
    .done(done), .rx_byte(rx_byte)
  );

  spi_flag_ctrl #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_q), .wr_data(wr_data), .rd_data(rd_data),
    .rd_stat(rd_stat), .wdata(cpu_wdata), .dma_mode(dma_q), .busy(busy),
    .done(done), .rx_byte(rx_byte), .load(load), .load_byte(load_byte),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_hold(rx_hold)
  );

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel == REG_DATA) begin
      cpu_rdata = rx_hold;
    end else begin
      cpu_rdata[RATE_W-1:0] = rate_q;
      cpu_rdata[ST_DMA]     = dma_q;
      cpu_rdata[ST_TXE]     = tx_empty;
      cpu_rdata[ST_RXF]     = rx_full;
    end
  end
endmodule

// File: rtl/spi_master_buf_chk.sv
module spi_master_buf_chk (
  input logic clk,
  input logic rst_q,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic done,
  input logic tx_empty,
  input logic rx_full,
  input logic cpu_rd,
  input logic cpu_sel,
  input logic dma_q
);
  // R2: a filled buffer with an idle shifter starts the shifter next cycle
  a_r2_handoff: assert property (@(posedge clk) disable iff (!rst_q)
    (!tx_empty && !busy) |=> busy);

  // R11: serial clock stays low while idle
  a_r11_sclk_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !sclk);

  // R4: MOSI holds steady while SCLK is high
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_q)
    sclk |-> $stable(mosi));

  // R6: end of byte raises receiver-full
  a_r6_full_on_done: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> rx_full);

  // R8: without a data read the flag cannot drop
  a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_full && !(cpu_rd && cpu_sel)) |=> rx_full);

  // R9: in DMA-style mode a data read alone drops the flag
  a_r9_dma_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (dma_q && cpu_rd && cpu_sel && !done) |=> !rx_full);
endmodule

bind spi_master_buf spi_master_buf_chk u_chk (
  .clk(clk), .rst_q(rst_q), .busy(busy), .sclk(sclk), .mosi(mosi),
  .done(done), .tx_empty(tx_empty), .rx_full(rx_full), .cpu_rd(cpu_rd),
  .cpu_sel(cpu_sel), .dma_q(dma_q)
);

// File: tb/spi_master_buf_test.sv
module spi_master_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 1'b0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       tx_empty, rx_full, sclk, mosi, miso;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_master_buf uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  // slave model: shifts out on falling SCLK, captures on rising SCLK
  logic [15:0] slv_tx = 16'h0000;
  logic [15:0] slv_rx = 16'h0000;
  assign miso = slv_tx[15];
  always @(posedge sclk) slv_rx <= {slv_rx[14:0], mosi};
  always @(negedge sclk) slv_tx <= {slv_tx[14:0], 1'b0};

  // cycle counter and SCLK period measurement
  int cyc = 0;
  int last_rise = 0;
  int last_per = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sclk) begin
    last_per  = cyc - last_rise;
    last_rise = cyc;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic wait_full(output int n);
    n = 0;
    while (!rx_full) begin
      @(negedge clk);
      n++;
    end
  endtask

  // one byte at a given rate; leaves rx_full set
  task automatic run_byte(input logic [1:0] rate, input logic dma,
                          input logic [7:0] txb, input logic [7:0] slvb);
    int n;
    int half;
    half = 1 << (2 * rate);
    bus_wr(1'b0, {5'b0, dma, rate});
    slv_tx = {slvb, 8'h00};
    bus_wr(1'b1, txb);
    chk("R2 tx_empty low after write", tx_empty, 0);
    @(negedge clk);
    chk("R2 tx_empty back after handoff", tx_empty, 1);
    n = 1;
    while (!rx_full) begin
      @(negedge clk);
      n++;
    end
    chk("R6 cycles to rx_full", n, 1 + 16 * half);
    chk("R3 sclk period", last_per, 2 * half);
    chk("R4 slave got byte", int'(slv_rx[7:0]), int'(txb));
    chk("R11 sclk low after byte", sclk, 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 sclk", sclk, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    bus_rd(1'b0, d);
    chk("R1 status", d, 8'h40);
  endtask

  task automatic t_rates;
    logic [7:0] d;
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    logic [7:0] sps  [4] = '{8'h5A, 8'hC3, 8'h00, 8'h80};
    for (int r = 0; r < 4; r++) begin
      run_byte(2'(r), 1'b0, pats[r], sps[r]);
      bus_rd(1'b0, d);
      chk("R7 status shows full", int'(d[7]), 1);
      chk("R3 status rate", int'(d[1:0]), r);
      bus_rd(1'b1, d);
      chk("R5 received byte", d, sps[r]);
      chk("R7 cleared by handshake", rx_full, 0);
    end
  endtask

  task automatic t_bare_read;
    logic [7:0] d;
    bus_rd(1'b0, d);
    chk("R8 flag clear before", int'(d[7]), 0);
    run_byte(2'd0, 1'b0, 8'h96, 8'h69);
    bus_rd(1'b1, d);
    chk("R5 data on bare read", d, 8'h69);
    chk("R8 still full", rx_full, 1);
    bus_rd(1'b1, d);
    chk("R8 still full again", rx_full, 1);
    bus_rd(1'b0, d);
    bus_rd(1'b1, d);
    chk("R7 cleared after handshake", rx_full, 0);
  endtask

  task automatic t_dma;
    logic [7:0] d;
    run_byte(2'd1, 1'b1, 8'h0F, 8'hF0);
    bus_rd(1'b1, d);
    chk("R5 dma data", d, 8'hF0);
    chk("R9 dma read clears", rx_full, 0);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_b2b;
    logic [7:0] d;
    int n, t1, t2;
    bus_wr(1'b0, 8'h00);
    slv_tx = 16'hE71B;
    bus_wr(1'b1, 8'hC5);
    @(negedge clk);
    bus_wr(1'b1, 8'h3A);
    chk("R10 buffer waits", tx_empty, 0);
    wait_full(n);
    t1 = cyc;
    bus_rd(1'b0, d);
    bus_rd(1'b1, d);
    chk("R5 first of pair", d, 8'hE7);
    chk("R10 buffer handed off", tx_empty, 1);
    wait_full(n);
    t2 = cyc;
    chk("R10 back to back spacing", t2 - t1, 17);
    bus_rd(1'b0, d);
    bus_rd(1'b1, d);
    chk("R5 second of pair", d, 8'h1B);
    chk("R4 slave got pair", int'(slv_rx), 16'hC53A);
    chk("R11 idle after pair", sclk, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rates();
    t_bare_read();
    t_dma();
    t_b2b();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule